// File: doc/BRIEF.md
# Single-Wire Half-Duplex Transaction Initiator

This block is the controlling end of a one-wire, open-drain, half-duplex link. After a start strobe it pulls the line low to wake the far end. It then sends a checked transaction index and releases the wire. Next it expects the target to prove its presence by letting the line rise and then pulling it low again. Once the target has answered, the initiator collects the target's bytes first, takes the wire back after a turnaround handshake, sends its own bytes, and ends with a closing pulse. The last step produces a result code.

Every bit on the wire lasts `BIT_CYC` clock cycles. Each chunk opens with a sync pulse: the line is low for `BIT_CYC` cycles and then high for `BIT_CYC/2` cycles. The data bits follow most-significant first, then one even-parity bit, which is the XOR of the data bits. The line is then held low. The receiver locks onto the rising edge of the sync pulse and samples each bit `BIT_CYC` cycles apart, with the first sample `BIT_CYC` cycles after that edge.

Received bytes leave through a valid/data port. Transmit bytes are pulled one at a time through a take strobe. Byte counts for both directions are given with the start strobe.

Top module: `lnk_initiator`

## Requirements
- R1: Out of reset and whenever not busy, the block drives the line high (`line_oe`=1, `line_out`=1), `busy`=0, and after reset `result`=0.
- R2: A start whose index exceeds `TABLE_MAX` is refused on the next cycle. In that cycle `done` pulses and `result`=4 (type error). `busy` stays 0 and the line stays driven high.
- R3: An accepted start holds the line low for `START_CYC` cycles, followed directly by the index chunk. Together these give a low span of `START_CYC+BIT_CYC` cycles. The index word is the index shifted left by 3, with the number of set bits of the index in the low 3 bits. It is sent as an `IDX_W+3`-bit chunk with even parity.
- R4: After the index chunk the line stays low for half a bit and is then released (`line_oe`=0). The block waits for the line to read high. If the line does not then go low within `POLL_CYC*(ACK_W+2)` cycles, the block drives the line high and ends with `result`=2 (no response).
- R5: After the acknowledge low, `rx_len` bytes are received as 8-bit chunks. Each byte appears once on `rx_data` with a one-cycle `rx_valid`.
- R6: If any received byte has a parity mismatch, the block receives all `rx_len` bytes and then ends with `result`=3 (data error). It drives the line high and never raises `tx_take`.
- R7: For turnaround, the block waits for the line to go low and then high. It keeps the wire released for `BIT_CYC` cycles after seeing it high, then drives it low for `BIT_CYC/2` cycles.
- R8: The block sends `tx_len` bytes as 8-bit chunks. Each byte is taken from `tx_data` in the cycle `tx_take` is high.
- R9: After the last transmit byte the line is held low for `BIT_CYC` cycles and then driven high, with `done` pulsing and `result`=1 (end).
- R10: A byte count of zero skips that direction's data phase, while the acknowledge and the turnaround still take place.
- R11: A start while busy is ignored. `result` is 0 during a transaction and keeps its final value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe |
| start_idx | input | IDX_W | Transaction index |
| rx_len | input | LEN_W | Bytes to receive from target |
| tx_len | input | LEN_W | Bytes to send to target |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| tx_data | input | 8 | Next byte to send |
| tx_take | output | 1 | Transmit byte consumed |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 none, 1 end, 2 no response, 3 data error, 4 type error |
| line_in | input | 1 | Sampled wire level |
| line_oe | output | 1 | Drive enable for the wire |
| line_out | output | 1 | Driven wire level |

## Verification
A wrong sequencer state shows up at the wire within one bit period. Examples are a low span of the wrong length, a turnaround gap other than `BIT_CYC+1` observed cycles, or the line released while idle. A target model decodes each chunk as the bits arrive, so a shifted or dropped bit in a framer gives a wrong byte or a parity failure at the end of that chunk. Faults in the result path show up at `done`: a wrong code, a take strobe during an aborted transaction, or a code that changes when an ignored start arrives.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

  typedef enum logic [2:0] {
    RES_NONE    = 3'd0,
    RES_END     = 3'd1,
    RES_NORESP  = 3'd2,
    RES_DATAERR = 3'd3,
    RES_TYPEERR = 3'd4
  } res_e;

  function automatic logic [3:0] ones8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + 4'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/lnk_chunk_tx.sv
module lnk_chunk_tx #(
  parameter int BIT_CYC = 8,
  parameter int CW      = 8
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [3:0] nbits,
  input  logic [7:0] data,
  output logic       val,
  output logic       done
);
  localparam int HALF_CYC = BIT_CYC / 2;

  typedef enum logic [2:0] {PH_IDLE, PH_SLO, PH_SHI, PH_DAT, PH_PAR} ph_e;

  ph_e          ph;
  logic [CW-1:0] cnt, plen;
  logic [7:0]   sh, mask;
  logic [3:0]   left;
  logic         par;

  assign mask = 8'((9'd1 << nbits) - 9'd1);

  always_comb begin
    case (ph)
      PH_SHI:  plen = CW'(HALF_CYC - 1);
      default: plen = CW'(BIT_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; cnt <= '0; sh <= '0; left <= '0;
      par <= 1'b0; val <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        ph   <= PH_SLO;
        cnt  <= '0;
        val  <= 1'b0;
        sh   <= data << (4'd8 - nbits);
        par  <= ^(data & mask);
        left <= nbits;
      end else if (ph != PH_IDLE) begin
        if (cnt == plen) begin
          cnt <= '0;
          case (ph)
            PH_SLO: begin ph <= PH_SHI; val <= 1'b1; end
            PH_SHI: begin ph <= PH_DAT; val <= sh[7]; sh <= sh << 1; left <= left - 4'd1; end
            PH_DAT: begin
              if (left == 4'd0) begin
                ph <= PH_PAR; val <= par;
              end else begin
                val <= sh[7]; sh <= sh << 1; left <= left - 4'd1;
              end
            end
            default: begin ph <= PH_IDLE; val <= 1'b0; done <= 1'b1; end
          endcase
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3: a chunk is only launched when the framer is free
  a_r3_go_when_idle: assert property (@(posedge clk) disable iff (rst)
    go |-> ph == PH_IDLE);

endmodule

// File: rtl/lnk_chunk_rx.sv
module lnk_chunk_rx #(
  parameter int BIT_CYC = 8,
  parameter int CW      = 8
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       line,
  input  logic [3:0] nbits,
  output logic [7:0] data,
  output logic       perr,
  output logic       done
);
  typedef enum logic [1:0] {RX_IDLE, RX_WLO, RX_WHI, RX_SMP} rph_e;

  rph_e          ph;
  logic [CW-1:0] cnt;
  logic [3:0]    left;
  logic          par;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= RX_IDLE; cnt <= '0; left <= '0; par <= 1'b0;
      data <= '0; perr <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        ph <= RX_WLO; data <= '0; par <= 1'b0; perr <= 1'b0;
      end else begin
        case (ph)
          RX_WLO: if (!line) ph <= RX_WHI;
          RX_WHI: if (line) begin ph <= RX_SMP; cnt <= '0; left <= nbits; end
          RX_SMP: begin
            if (cnt == CW'(BIT_CYC - 1)) begin
              cnt <= '0;
              if (left != 4'd0) begin
                data <= {data[6:0], line};
                par  <= par ^ line;
                left <= left - 4'd1;
              end else begin
                perr <= par ^ line;
                done <= 1'b1;
                ph   <= RX_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R5: a new chunk is only armed when the previous one has completed
  a_r5_go_when_idle: assert property (@(posedge clk) disable iff (rst)
    go |-> ph == RX_IDLE);

endmodule

// File: rtl/lnk_initiator.sv
module lnk_initiator
  import lnk_pkg::*;
#(
  parameter int BIT_CYC   = 8,
  parameter int START_CYC = 3,
  parameter int POLL_CYC  = 2,
  parameter int ACK_W     = 4,
  parameter int IDX_W     = 4,
  parameter int TABLE_MAX = 9,
  parameter int LEN_W     = 4
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [LEN_W-1:0] rx_len,
  input  logic [LEN_W-1:0] tx_len,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  input  logic [7:0]       tx_data,
  output logic             tx_take,
  output logic             busy,
  output logic             done,
  output logic [2:0]       result,
  input  logic             line_in,
  output logic             line_oe,
  output logic             line_out
);
  localparam int HALF_CYC  = BIT_CYC / 2;
  localparam int ACK_LIMIT = POLL_CYC * (ACK_W + 2);
  localparam int CW        = $clog2(BIT_CYC + START_CYC + ACK_LIMIT + 2) + 1;
  localparam int IW        = IDX_W + 3;

  typedef enum logic [3:0] {
    S_IDLE, S_STLO, S_IDX, S_TAIL, S_AHI, S_ALO, S_RX,
    S_TSLO, S_TSHI, S_TWAIT, S_TLOW, S_TX, S_FIN
  } st_e;

  st_e              st;
  logic [CW-1:0]    cnt;
  logic             drv_out;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] rxn, txn, left;
  logic             perr_q;

  logic       fr_go, fr_val, fr_done;
  logic [7:0] fr_data;
  logic [3:0] fr_bits;
  logic       rc_go, rc_perr, rc_done;
  logic [7:0] rc_data;
  logic [3:0] ones;
  logic [7:0] idx_word;

  assign ones     = ones8(8'(idx_q));
  assign idx_word = 8'({idx_q, ones[2:0]});

  assign fr_go = (st == S_STLO && cnt == CW'(START_CYC - 1))
              || (st == S_TLOW && cnt == CW'(HALF_CYC - 1) && txn != '0)
              || (st == S_TX && fr_done && left != LEN_W'(1));
  assign rc_go = (st == S_ALO && !line_in && rxn != '0)
              || (st == S_RX && rc_done && left != LEN_W'(1));
  assign fr_data = (st == S_STLO) ? idx_word : tx_data;
  assign fr_bits = (st == S_STLO) ? 4'(IW) : 4'd8;
  assign tx_take = fr_go && (st != S_STLO);
  assign line_out = (st == S_IDX || st == S_TX) ? fr_val : drv_out;

  lnk_chunk_tx #(.BIT_CYC(BIT_CYC), .CW(CW)) u_tx (
    .clk(clk), .rst(rst), .go(fr_go), .nbits(fr_bits), .data(fr_data),
    .val(fr_val), .done(fr_done));

  lnk_chunk_rx #(.BIT_CYC(BIT_CYC), .CW(CW)) u_rx (
    .clk(clk), .rst(rst), .go(rc_go), .line(line_in), .nbits(4'd8),
    .data(rc_data), .perr(rc_perr), .done(rc_done));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; line_oe <= 1'b1; drv_out <= 1'b1;
      idx_q <= '0; rxn <= '0; txn <= '0; left <= '0; perr_q <= 1'b0;
      busy <= 1'b0; done <= 1'b0; result <= RES_NONE;
      rx_valid <= 1'b0; rx_data <= '0;
    end else begin
      done     <= 1'b0;
      rx_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (start_idx > IDX_W'(TABLE_MAX)) begin
            result <= RES_TYPEERR;
            done   <= 1'b1;
          end else begin
            result <= RES_NONE; busy <= 1'b1;
            idx_q <= start_idx; rxn <= rx_len; txn <= tx_len; perr_q <= 1'b0;
            drv_out <= 1'b0; cnt <= '0; st <= S_STLO;
          end
        end
        S_STLO: if (cnt == CW'(START_CYC - 1)) begin cnt <= '0; st <= S_IDX; end
                else cnt <= cnt + 1'b1;
        S_IDX: if (fr_done) begin cnt <= '0; drv_out <= 1'b0; st <= S_TAIL; end
        S_TAIL: if (cnt == CW'(HALF_CYC - 1)) begin cnt <= '0; line_oe <= 1'b0; st <= S_AHI; end
                else cnt <= cnt + 1'b1;
        S_AHI: if (line_in) begin cnt <= '0; st <= S_ALO; end
        S_ALO: begin
          if (!line_in) begin
            left <= rxn;
            st   <= (rxn != '0) ? S_RX : S_TSLO;
          end else if (cnt == CW'(ACK_LIMIT - 1)) begin
            line_oe <= 1'b1; drv_out <= 1'b1; result <= RES_NORESP;
            done <= 1'b1; busy <= 1'b0; st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_RX: if (rc_done) begin
          rx_valid <= 1'b1;
          rx_data  <= rc_data;
          if (left == LEN_W'(1)) begin
            if (perr_q || rc_perr) begin
              line_oe <= 1'b1; drv_out <= 1'b1; result <= RES_DATAERR;
              done <= 1'b1; busy <= 1'b0; st <= S_IDLE;
            end else st <= S_TSLO;
          end else begin
            left   <= left - 1'b1;
            perr_q <= perr_q | rc_perr;
          end
        end
        S_TSLO: if (!line_in) st <= S_TSHI;
        S_TSHI: if (line_in) begin cnt <= '0; st <= S_TWAIT; end
        S_TWAIT: if (cnt == CW'(BIT_CYC - 1)) begin
          cnt <= '0; line_oe <= 1'b1; drv_out <= 1'b0; st <= S_TLOW;
        end else cnt <= cnt + 1'b1;
        S_TLOW: if (cnt == CW'(HALF_CYC - 1)) begin
          cnt  <= '0;
          left <= txn;
          st   <= (txn != '0) ? S_TX : S_FIN;
        end else cnt <= cnt + 1'b1;
        S_TX: if (fr_done) begin
          if (left == LEN_W'(1)) begin cnt <= '0; drv_out <= 1'b0; st <= S_FIN; end
          else left <= left - 1'b1;
        end
        S_FIN: if (cnt == CW'(BIT_CYC - 1)) begin
          cnt <= '0; drv_out <= 1'b1; result <= RES_END;
          done <= 1'b1; busy <= 1'b0; st <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: idle means the wire is actively held high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (line_oe && line_out));
  // R2: out-of-range index refused without starting
  a_r2_type_err: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && start_idx > IDX_W'(TABLE_MAX)) |=> (result == RES_TYPEERR && !busy && done));
  // R4: the wire is only released inside a transaction
  a_r4_release_busy: assert property (@(posedge clk) disable iff (rst)
    !line_oe |-> busy);
  // R5: received bytes only surface during a transaction or at its end
  a_r5_valid_in_txn: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (busy || done));
  // R6: no transmit byte after a parity failure
  a_r6_no_take_on_err: assert property (@(posedge clk) disable iff (rst)
    tx_take |-> !perr_q);
  // R8: one take strobe per byte
  a_r8_take_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_take |=> !tx_take);
  // R11: result is held between transactions
  a_r11_result_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(result));

endmodule

// File: tb/lnk_initiator_test.sv
module lnk_initiator_test;
  localparam int BIT   = 8;
  localparam int HALF  = 4;
  localparam int STRT  = 3;
  localparam int TMAX  = 9;

  logic clk = 0, rst = 1;
  logic start = 0;
  logic [3:0] start_idx = '0, rx_len = '0, tx_len = '0;
  logic rx_valid, tx_take, busy, done, line_oe, line_out;
  logic [7:0] rx_data, tx_data;
  logic [2:0] result;
  logic t_oe = 0, t_out = 1;
  wire  line = (line_oe ? line_out : 1'b1) & (t_oe ? t_out : 1'b1);

  int n_chk = 0, n_err = 0, cyc = 0;
  bit mon = 0;
  logic [7:0] ti_arr [16];
  logic [7:0] tg_arr [16];
  int ti_ptr = 0, takes = 0;
  logic [7:0] got_rx[$];
  logic [7:0] got_tx[$];
  int idx_word, low_span, turn_gap;
  bit idx_pok;

  always #5 clk = ~clk;

  assign tx_data = ti_arr[ti_ptr[3:0]];

  lnk_initiator uut (
    .clk(clk), .rst(rst), .start(start), .start_idx(start_idx),
    .rx_len(rx_len), .tx_len(tx_len), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_data(tx_data), .tx_take(tx_take), .busy(busy), .done(done),
    .result(result), .line_in(line), .line_oe(line_oe), .line_out(line_out));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) if (tx_take) ti_ptr <= ti_ptr + 1;

  always @(negedge clk) begin
    cyc++;
    if (rx_valid) got_rx.push_back(rx_data);
    if (tx_take) takes++;
    if (mon && !rst && !busy) chk(line_oe && line_out, "R1 idle drive", {line_oe, line_out}, 3);
    if (cyc > 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog cycles=%0d expected<150000", cyc);
      report();
    end
  end

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  task automatic recv_chunk(input int nb, output int word, output bit pok, output int span);
    bit p = 0;
    int n = 0;
    while (line) @(negedge clk);
    while (!line) begin n++; @(negedge clk); end
    span = n; word = 0;
    for (int k = 0; k < nb; k++) begin
      repeat (BIT) @(negedge clk);
      word = (word << 1) | int'(line);
      p ^= line;
    end
    repeat (BIT) @(negedge clk);
    pok = (line == p);
  endtask

  task automatic send_chunk(input logic [7:0] b, input bit flip);
    t_out = 0; repeat (BIT) @(negedge clk);
    t_out = 1; repeat (HALF) @(negedge clk);
    for (int k = 7; k >= 0; k--) begin
      t_out = b[k]; repeat (BIT) @(negedge clk);
    end
    t_out = (^b) ^ flip; repeat (BIT) @(negedge clk);
    t_out = 0;
  endtask

  task automatic target(input bit ack, input int nrx, input int ntx, input int bad_at, input bit derr);
    int w, sp; bit pk;
    recv_chunk(7, idx_word, idx_pok, low_span);
    if (!ack) return;
    while (line) @(negedge clk);
    while (!line) @(negedge clk);
    repeat (3) @(negedge clk);
    t_oe = 1; t_out = 0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < nrx; k++) send_chunk(tg_arr[k], k == bad_at);
    if (derr) begin t_oe = 0; return; end
    t_out = 0; repeat (BIT) @(negedge clk);
    t_oe = 0;
    turn_gap = 0;
    do begin @(negedge clk); turn_gap++; end while (line);
    for (int k = 0; k < ntx; k++) begin
      recv_chunk(8, w, pk, sp);
      got_tx.push_back(8'(w));
      chk(pk, "R8 tx parity", pk, 1);
    end
  endtask

  task automatic run_txn(input int idx, input int nrx, input int ntx, input bit ack,
                         input int bad_at, input int exp_res, input bit poke);
    int wd = 0;
    int r_hold;
    got_rx.delete(); got_tx.delete();
    takes = 0; ti_ptr = 0; turn_gap = -1; t_oe = 0;
    for (int k = 0; k < 16; k++) begin
      ti_arr[k] = 8'(idx * 13 + k * 59 + 129);
      tg_arr[k] = 8'(idx * 37 + k * 91 + 5);
    end
    @(negedge clk);
    start = 1; start_idx = 4'(idx); rx_len = 4'(nrx); tx_len = 4'(ntx);
    @(negedge clk);
    start = 0;
    fork
      target(ack, nrx, ntx, bad_at, exp_res == 3);
      begin
        if (poke) begin
          repeat (20) @(negedge clk);
          chk(result == 0, "R11 result cleared while busy", result, 0);
          start = 1; start_idx = 4'd15; @(negedge clk); start = 0;
        end
        while (!done && wd < 20000) begin @(negedge clk); wd++; end
      end
    join
    while (!done && wd < 20000) begin @(negedge clk); wd++; end
    chk(result == 3'(exp_res), exp_res == 1 ? "R9 end code" : exp_res == 2 ? "R4 no-response code" : "R6 data-error code", result, exp_res);
    chk(line_oe && line_out && !busy, "R9 line high after done", {line_oe, line_out}, 3);
    chk(idx_word == ((idx << 3) | (ones(idx) & 7)), "R3 index word", idx_word, (idx << 3) | (ones(idx) & 7));
    chk(idx_pok, "R3 index parity", idx_pok, 1);
    chk(low_span == STRT + BIT, "R3 start low span", low_span, STRT + BIT);
    if (ack) begin
      chk(got_rx.size() == nrx, nrx == 0 ? "R10 rx skipped" : "R5 rx count", got_rx.size(), nrx);
      for (int k = 0; k < got_rx.size() && k < nrx; k++)
        chk(got_rx[k] == tg_arr[k], "R5 rx byte", got_rx[k], tg_arr[k]);
    end
    if (exp_res == 1) begin
      chk(turn_gap == BIT + 1, "R7 turnaround gap", turn_gap, BIT + 1);
      chk(takes == ntx, ntx == 0 ? "R10 tx skipped" : "R8 take count", takes, ntx);
      chk(got_tx.size() == ntx, "R8 tx count", got_tx.size(), ntx);
      for (int k = 0; k < got_tx.size() && k < ntx; k++)
        chk(got_tx[k] == ti_arr[k], "R8 tx byte", got_tx[k], ti_arr[k]);
    end else begin
      chk(takes == 0, "R6 no take on abort", takes, 0);
    end
    r_hold = result;
    repeat (10) @(negedge clk);
    chk(result == 3'(r_hold), "R11 result held", result, r_hold);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(result == 0 && !busy, "R1 reset state", {busy, result}, 0);
    chk(line_oe && line_out, "R1 reset line", {line_oe, line_out}, 3);
    mon = 1;
    run_txn(5, 3, 2, 1, -1, 1, 1);
    run_txn(9, 0, 3, 1, -1, 1, 0);
    run_txn(0, 2, 0, 1, -1, 1, 0);
    run_txn(7, 2, 2, 1, 1, 3, 0);
    run_txn(3, 1, 1, 0, -1, 2, 0);
    @(negedge clk);
    start = 1; start_idx = 4'd12;
    @(negedge clk);
    start = 0;
    chk(done && result == 4 && !busy, "R2 type error", result, 4);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(line_oe && line_out && !busy, "R2 no line activity", {line_oe, line_out}, 3);
    end
    run_txn(TMAX, 1, 1, 1, -1, 1, 0);
    report();
  end

endmodule